// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver

This block is the slave-side serial front end of a display controller. A host sends command and data bytes over a serial link that has a clock, a data line and an active-low chip select. A static mode input picks one of two framings. With the mode input low, every frame is eight bits long and a separate pin tags the byte as command or data. With the mode input high, every frame is nine bits long and its first bit carries the tag.

Each finished byte crosses into the core clock domain through a toggle handshake. The core then sees a one-cycle strobe together with the byte and its tag. The block also supports register readback. After the host sends a command that falls in the read range, the block turns the data line around and shifts bytes out on falling clock edges. It keeps doing so until chip select rises.

Top module: `dual_link_cmd_rx`

## Requirements
- R1: While `cs_n` is high, the link logic is held cleared. A frame cut short by `cs_n` rising is discarded with no strobe, and the next frame starts again at bit 0.
- R2: With `mode_3w` low, a frame is 8 bits sampled on rising `sck` edges, most significant bit first. The tag is the level of `dc_pin` at the final edge: 0 means command and 1 means data.
- R3: With `mode_3w` high, a frame is 9 bits. The first bit is the tag (0 command, 1 data), followed by the byte MSB first.
- R4: The frame length follows `mode_3w`: 8 bits when it is low, 9 bits when it is high. The internal bit counter never reaches the frame length.
- R5: Each completed frame gives exactly one single-cycle `rx_vld` pulse in the `clk` domain. `rx_byte` and `rx_is_data` change only together with that pulse and hold their values between pulses.
- R6: A read command is a command-tagged byte whose top five bits are 10101, that is 0xA8 to 0xAF. Data-tagged bytes never start a read. In 8-bit mode, read-out begins on the falling edge right after the command's last rising edge. `rd_data` is loaded on the first falling edge of each read byte, and bits go out MSB first, one per falling edge. Read bytes follow one another without a gap.
- R7: In 9-bit mode, one more rising edge follows a read command. If `sdi` is 1 on that edge, read-out starts on the next falling edge. If it is 0, no read happens and that bit is taken as the tag of a new command frame.
- R8: `sdo_en` is high only during read-out and drops as soon as `cs_n` rises. `sdo` is 0 whenever `sdo_en` is low.
- R9: During read-out, rising edges capture nothing and produce no strobe.
- R10: The read command byte itself is delivered to the core as a command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| dc_pin | input | 1 | Command (0) / data (1) tag used in 8-bit mode |
| mode_3w | input | 1 | 0: 8-bit frames with external tag; 1: 9-bit frames with in-band tag |
| rd_data | input | 8 | Byte to return during read-out |
| sdo | output | 1 | Serial data out during read-out |
| sdo_en | output | 1 | Output enable for the shared data line |
| rx_vld | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | Tag of the received byte: 1 data, 0 command |

## Verification
The assertions check four things on every cycle: the output enable never runs outside chip select, the data line stays quiet while it is disabled, the core strobe is a single pulse and its payload changes only with it, and the bit counter stays inside the frame length of the current mode. They also check that no frame completes while read-out is active. Only the bench scenarios can show the rest. That covers the bit order and tag of each received byte, that partial frames are dropped, that read bytes come out in the right order on the right falling edge, and that a 0 after a 9-bit read command cancels the read and opens a new command frame.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
  localparam int DW    = 8;
  localparam int CNT_W = $clog2(DW + 2);
  localparam int OCNT_W = $clog2(DW);

  typedef logic [DW-1:0] byte_t;

  // Bits per frame for the selected link framing.
  function automatic int unsigned frame_bits(input logic three_wire);
    return three_wire ? DW + 1 : DW;
  endfunction

  // True when a command byte falls in the read range.
  function automatic logic read_hit(input byte_t b, input byte_t mask, input byte_t match);
    return (b & mask) == match;
  endfunction
endpackage

// File: rtl/dlrx_shift_in.sv
module dlrx_shift_in
  import dlrx_pkg::*;
#(
  parameter byte_t RD_MASK  = 8'hF8,
  parameter byte_t RD_MATCH = 8'hA8
) (
  input  logic             sck,
  input  logic             link_rst,
  input  logic             sdi,
  input  logic             dc_pin,
  input  logic             three_wire,
  output logic             frame_done,
  output byte_t            frame_byte,
  output logic             frame_tag,
  output logic             rd_go,
  output logic [CNT_W-1:0] bit_cnt
);
  logic [DW-2:0]    sh_q;
  logic             flag_q;
  logic             rd_pend_q;
  logic             rd_go_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             normal_bit;
  logic             cmd_is_read;

  assign last_idx    = CNT_W'(frame_bits(three_wire) - 1);
  assign normal_bit  = !rd_go_q && !rd_pend_q;
  assign frame_done  = normal_bit && (cnt_q == last_idx);
  assign frame_byte  = {sh_q, sdi};
  assign frame_tag   = three_wire ? flag_q : dc_pin;
  assign cmd_is_read = read_hit(frame_byte, RD_MASK, RD_MATCH) && !frame_tag;
  assign rd_go       = rd_go_q;
  assign bit_cnt     = cnt_q;

  always_ff @(posedge sck or posedge link_rst) begin
    if (link_rst) begin
      sh_q      <= '0;
      flag_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_go_q   <= 1'b0;
      cnt_q     <= '0;
    end else if (rd_go_q) begin
      // read-out owns the line: rising edges are ignored
      cnt_q <= cnt_q;
    end else if (rd_pend_q) begin
      rd_pend_q <= 1'b0;
      if (sdi) begin
        rd_go_q <= 1'b1;
      end else begin
        flag_q <= 1'b0;
        cnt_q  <= CNT_W'(1);
      end
    end else if (frame_done) begin
      cnt_q <= '0;
      if (cmd_is_read) begin
        if (three_wire) rd_pend_q <= 1'b1;
        else            rd_go_q   <= 1'b1;
      end
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (three_wire && cnt_q == '0) flag_q <= sdi;
      else                           sh_q   <= {sh_q[DW-3:0], sdi};
    end
  end
endmodule

// File: rtl/dlrx_shift_out.sv
module dlrx_shift_out
  import dlrx_pkg::*;
(
  input  logic  sck,
  input  logic  link_rst,
  input  logic  rd_go,
  input  byte_t rd_data,
  output logic  sdo,
  output logic  sdo_en
);
  byte_t             osh_q;
  logic [OCNT_W-1:0] ocnt_q;
  logic              oen_q;

  always_ff @(negedge sck or posedge link_rst) begin
    if (link_rst) begin
      osh_q  <= '0;
      ocnt_q <= '0;
      oen_q  <= 1'b0;
    end else if (rd_go) begin
      oen_q <= 1'b1;
      if (ocnt_q == '0) osh_q <= rd_data;
      else              osh_q <= {osh_q[DW-2:0], 1'b0};
      if (ocnt_q == OCNT_W'(DW - 1)) ocnt_q <= '0;
      else                           ocnt_q <= ocnt_q + OCNT_W'(1);
    end
  end

  assign sdo    = osh_q[DW-1] & oen_q;
  assign sdo_en = oen_q;
endmodule

// File: rtl/dlrx_byte_cdc.sv
module dlrx_byte_cdc
  import dlrx_pkg::*;
(
  input  logic  sck,
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_en,
  input  byte_t cap_byte,
  input  logic  cap_tag,
  output logic  rx_vld,
  output byte_t rx_byte,
  output logic  rx_is_data
);
  byte_t      hold_byte_q;
  logic       hold_tag_q;
  logic       tgl_q;
  logic [2:0] sync_q;
  logic       new_byte;

  // Link side: kept across chip-select release so the last byte still crosses.
  always_ff @(posedge sck or negedge rst_n) begin
    if (!rst_n) begin
      hold_byte_q <= '0;
      hold_tag_q  <= 1'b0;
      tgl_q       <= 1'b0;
    end else if (cap_en) begin
      hold_byte_q <= cap_byte;
      hold_tag_q  <= cap_tag;
      tgl_q       <= ~tgl_q;
    end
  end

  assign new_byte = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      rx_vld     <= 1'b0;
      rx_byte    <= '0;
      rx_is_data <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], tgl_q};
      rx_vld <= new_byte;
      if (new_byte) begin
        rx_byte    <= hold_byte_q;
        rx_is_data <= hold_tag_q;
      end
    end
  end
endmodule

// File: rtl/dual_link_cmd_rx.sv
module dual_link_cmd_rx
  import dlrx_pkg::*;
#(
  parameter byte_t RD_MASK  = 8'hF8,
  parameter byte_t RD_MATCH = 8'hA8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        sdi,
  input  logic        dc_pin,
  input  logic        mode_3w,
  input  logic [7:0]  rd_data,
  output logic        sdo,
  output logic        sdo_en,
  output logic        rx_vld,
  output logic [7:0]  rx_byte,
  output logic        rx_is_data
);
  logic             link_rst;
  logic             frame_done;
  byte_t            frame_byte;
  logic             frame_tag;
  logic             rd_go;
  logic [CNT_W-1:0] bit_cnt;

  assign link_rst = cs_n | ~rst_n;

  dlrx_shift_in #(.RD_MASK(RD_MASK), .RD_MATCH(RD_MATCH)) u_in (
    .sck        (sck),
    .link_rst   (link_rst),
    .sdi        (sdi),
    .dc_pin     (dc_pin),
    .three_wire (mode_3w),
    .frame_done (frame_done),
    .frame_byte (frame_byte),
    .frame_tag  (frame_tag),
    .rd_go      (rd_go),
    .bit_cnt    (bit_cnt)
  );

  dlrx_shift_out u_out (
    .sck      (sck),
    .link_rst (link_rst),
    .rd_go    (rd_go),
    .rd_data  (rd_data),
    .sdo      (sdo),
    .sdo_en   (sdo_en)
  );

  dlrx_byte_cdc u_cdc (
    .sck        (sck),
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (frame_done),
    .cap_byte   (frame_byte),
    .cap_tag    (frame_tag),
    .rx_vld     (rx_vld),
    .rx_byte    (rx_byte),
    .rx_is_data (rx_is_data)
  );
endmodule

// File: rtl/dlrx_checker.sv
module dlrx_checker
  import dlrx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             cs_n,
  input logic             link_rst,
  input logic             sdo,
  input logic             sdo_en,
  input logic             frame_done,
  input logic             rd_go,
  input logic             rx_vld,
  input logic [7:0]       rx_byte,
  input logic             mode_3w,
  input logic [CNT_W-1:0] bit_cnt
);
  p_oen_inside_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> !cs_n);

  p_sdo_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  p_payload_with_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_vld);

  p_no_capture_in_read_r9: assert property (@(posedge sck) disable iff (link_rst)
    sdo_en |-> !frame_done);

  p_readout_needs_go_r6: assert property (@(posedge sck) disable iff (link_rst)
    sdo_en |-> rd_go);

  p_cnt_bound_r4: assert property (@(posedge sck) disable iff (link_rst)
    bit_cnt < CNT_W'(frame_bits(mode_3w)));
endmodule

bind dual_link_cmd_rx dlrx_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .cs_n       (cs_n),
  .link_rst   (link_rst),
  .sdo        (sdo),
  .sdo_en     (sdo_en),
  .frame_done (frame_done),
  .rd_go      (rd_go),
  .rx_vld     (rx_vld),
  .rx_byte    (rx_byte),
  .mode_3w    (mode_3w),
  .bit_cnt    (bit_cnt)
);

// File: tb/dual_link_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module dual_link_cmd_rx_tb_top;
  localparam time H = 40ns;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0;
  logic sdi = 1'b0, dc_pin = 1'b0, mode_3w = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic sdo, sdo_en, rx_vld, rx_is_data;
  logic [7:0] rx_byte;

  int nchk = 0, nerr = 0;
  int got_n = 0, exp_n = 0;
  logic [7:0] got_b [0:63];
  logic       got_t [0:63];
  logic [7:0] exp_b [0:63];
  logic       exp_t [0:63];

  always #4ns clk = ~clk;

  dual_link_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .dc_pin(dc_pin), .mode_3w(mode_3w), .rd_data(rd_data),
    .sdo(sdo), .sdo_en(sdo_en), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .rx_is_data(rx_is_data)
  );

  always @(negedge clk) begin
    if (rx_vld && got_n < 64) begin
      got_b[got_n] = rx_byte;
      got_t[got_n] = rx_is_data;
      got_n = got_n + 1;
    end
  end

  function automatic bit is_rd(input logic [7:0] b);
    return b[7:3] == 5'b10101;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic din, output logic dout);
    sdi = din;
    #H;
    dout = sdo;
    sck = 1'b1;
    #H;
    sck = 1'b0;
  endtask

  task automatic start_tx(input logic m3);
    mode_3w = m3;
    #H;
    cs_n = 1'b0;
    #H;
  endtask

  task automatic end_tx;
    #H;
    cs_n = 1'b1;
    #(4*H);
  endtask

  task automatic send_byte(input logic m3, input logic tag, input logic [7:0] b);
    logic d;
    if (m3) bit_x(tag, d);
    else dc_pin = tag;
    for (int i = 7; i >= 0; i--) bit_x(b[i], d);
  endtask

  task automatic push_exp(input logic [7:0] b, input logic t);
    exp_b[exp_n] = b;
    exp_t[exp_n] = t;
    exp_n++;
  endtask

  task automatic compare_rx(input string req);
    chk(got_n == exp_n, {req, " strobe count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_b[i] == exp_b[i], {req, " byte"}, got_b[i], exp_b[i]);
      chk(got_t[i] == exp_t[i], {req, " tag"}, got_t[i], exp_t[i]);
    end
    got_n = 0;
    exp_n = 0;
  endtask

  // read nbytes after the turnaround, updating rd_data once each byte is loaded
  task automatic read_bytes(input logic [7:0] v0, input logic [7:0] v1, input int nb, input string req);
    logic [7:0] got;
    logic d;
    for (int j = 0; j < nb; j++) begin
      got = '0;
      for (int i = 0; i < 8; i++) begin
        if (i == 1) rd_data = v1;
        bit_x(1'($urandom % 2), d);
        got = {got[6:0], d};
      end
      chk(got == ((j == 0) ? v0 : v1), req, got, (j == 0) ? v0 : v1);
    end
  endtask

  initial begin
    #1ms;
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic d;
    int unsigned seed;
    seed = 32'd7;
    d = 1'($urandom(seed));
    #50ns;
    rst_n = 1'b1;
    #50ns;
    // reset state
    chk(rx_vld == 1'b0, "R5 reset vld", rx_vld, 0);
    chk(rx_byte == 8'h00, "R5 reset byte", rx_byte, 0);
    chk(sdo_en == 1'b0, "R8 reset oe", sdo_en, 0);

    // R2: 8-bit frames, command then data
    start_tx(1'b0);
    send_byte(1'b0, 1'b0, 8'h12); push_exp(8'h12, 1'b0);
    chk(sdo_en == 1'b0, "R8 oe low on write", sdo_en, 0);
    send_byte(1'b0, 1'b1, 8'hE5); push_exp(8'hE5, 1'b1);
    end_tx;
    compare_rx("R2");

    // R3: 9-bit frames with in-band tag
    start_tx(1'b1);
    send_byte(1'b1, 1'b1, 8'h81); push_exp(8'h81, 1'b1);
    send_byte(1'b1, 1'b0, 8'h3C); push_exp(8'h3C, 1'b0);
    end_tx;
    compare_rx("R3");

    // R1: partial frame discarded in both modes
    start_tx(1'b0);
    dc_pin = 1'b1;
    for (int i = 0; i < 5; i++) bit_x(1'b1, d);
    end_tx;
    start_tx(1'b0);
    send_byte(1'b0, 1'b1, 8'h3C); push_exp(8'h3C, 1'b1);
    end_tx;
    compare_rx("R1 8-bit partial");
    start_tx(1'b1);
    for (int i = 0; i < 4; i++) bit_x(1'b1, d);
    end_tx;
    start_tx(1'b1);
    send_byte(1'b1, 1'b0, 8'h5B); push_exp(8'h5B, 1'b0);
    end_tx;
    compare_rx("R1 9-bit partial");

    // R6: data-tagged byte in read range starts no read
    start_tx(1'b0);
    send_byte(1'b0, 1'b1, 8'hA9); push_exp(8'hA9, 1'b1);
    #1ns;
    chk(sdo_en == 1'b0, "R6 data tag no read", sdo_en, 0);
    end_tx;
    compare_rx("R6 data tag");

    // R6/R9/R10: 8-bit read of two bytes
    rd_data = 8'h5A;
    start_tx(1'b0);
    send_byte(1'b0, 1'b0, 8'hA9); push_exp(8'hA9, 1'b0);
    #1ns;
    chk(sdo_en == 1'b1, "R8 oe after read cmd", sdo_en, 1);
    read_bytes(8'h5A, 8'hC3, 2, "R6 read byte");
    #H;
    cs_n = 1'b1;
    #1ns;
    chk(sdo_en == 1'b0, "R8 oe drops with cs", sdo_en, 0);
    #(4*H);
    compare_rx("R9 R10 read 8-bit");

    // R7: 9-bit read with flag 1
    rd_data = 8'h96;
    start_tx(1'b1);
    send_byte(1'b1, 1'b0, 8'hAC); push_exp(8'hAC, 1'b0);
    #1ns;
    chk(sdo_en == 1'b0, "R7 oe waits for flag", sdo_en, 0);
    bit_x(1'b1, d);
    #1ns;
    chk(sdo_en == 1'b1, "R7 oe after flag", sdo_en, 1);
    read_bytes(8'h96, 8'h96, 1, "R7 read byte");
    end_tx;
    compare_rx("R7 read 9-bit");

    // R7: flag 0 cancels the read and opens a command frame
    start_tx(1'b1);
    send_byte(1'b1, 1'b0, 8'hAB); push_exp(8'hAB, 1'b0);
    send_byte(1'b1, 1'b0, 8'h11); push_exp(8'h11, 1'b0);
    #1ns;
    chk(sdo_en == 1'b0, "R7 cancel oe", sdo_en, 0);
    end_tx;
    compare_rx("R7 cancel");

    // R2 R3 R4 R5: random traffic in both modes
    for (int t = 0; t < 40; t++) begin
      logic m3;
      int nb;
      m3 = 1'($urandom % 2);
      nb = 1 + int'($urandom % 4);
      start_tx(m3);
      for (int k = 0; k < nb; k++) begin
        logic [7:0] b;
        logic tg;
        b  = 8'($urandom);
        tg = 1'($urandom % 2);
        if (!tg && is_rd(b)) b[6] = ~b[6];
        send_byte(m3, tg, b);
        push_exp(b, tg);
      end
      end_tx;
      compare_rx(m3 ? "R3 R4 random" : "R2 R4 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule